// File: doc/BRIEF.md
# Streaming 3x3 Cluster Finder

This block watches a raster stream of 14-bit pixel samples, one per clock when `in_valid` is high, and slides a 3x3 neighbourhood over the frame. Each time the neighbourhood is complete, the block decides whether the middle pixel is the seed of a particle hit. If it is, the block emits one record. The record holds the seed's column and row, the nine-pixel signal total, and the two signed first moments. A downstream unit divides each moment by the total to get a sub-pixel offset from the seed.

A hit is accepted only when four tests hold together. The seed must stand above a seed threshold. The nine-pixel total must stand above a cluster threshold. The seed must dominate the ring of eight around it by a programmable shape factor. The seed must also be a local maximum. No divider is used: the shape test is a cross-multiplication. The whole decision and the moments are computed in parallel, so one window is evaluated per accepted pixel with no stall.

Two row memories hold the previous two lines, and a register window holds the last three columns. A pulse marks the evaluation of the frame's final window.

Top module: `cf_cluster_finder`

## Requirements
- R1: A record is produced only if the seed (middle) pixel is strictly greater than `cfg_seed`; a seed equal to `cfg_seed` is rejected.
- R2: A record is produced only if the sum of all nine pixels is strictly greater than `cfg_total`; equality is rejected.
- R3: A record is produced only if seed × 16 > `cfg_shape` × (sum of the eight ring pixels), where `cfg_shape` is unsigned with 4 fractional bits (16 means 1.0); equality is rejected.
- R4: A record is produced only if the seed is greater than or equal to every ring pixel; a ring pixel equal to the seed does not block it, a larger one does.
- R5: Windows whose middle lies in column 0, column IMG_W-1, row 0 or row IMG_H-1 never produce a record.
- R6: A record carries `out_x`/`out_y` = seed column/row (column counted from 0 at each line start, row from 0 at frame start), `out_sum` = nine-pixel sum, `out_mom_x` = right column sum minus left column sum, `out_mom_y` = lower row sum minus upper row sum (row number increasing downward), both two's complement.
- R7: `out_valid` is high for exactly one cycle, two clock edges after the edge that captures the pixel at (seed column + 1, seed row + 1); cycles with `in_valid` low neither advance the scan nor shift the window.
- R8: `out_eof` is a single-cycle pulse two clock edges after the edge that captures the pixel at (IMG_W-1, IMG_H-1), coinciding with the result of the frame's last window.
- R9: A pixel accepted with `in_sof` high is taken as (0,0), restarting the scan even in the middle of a frame.
- R10: While `rst_n` is low, and on the first cycle after it, `out_valid` and `out_eof` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel sample present this cycle |
| in_sof | input | 1 | Marks the first pixel of a frame |
| in_pix | input | 14 | Pixel amplitude, unsigned |
| cfg_seed | input | 14 | Seed threshold |
| cfg_total | input | 18 | Nine-pixel total threshold |
| cfg_shape | input | 8 | Shape factor, 4 fractional bits |
| out_valid | output | 1 | Record present |
| out_x | output | 9 | Seed column |
| out_y | output | 9 | Seed row |
| out_sum | output | 18 | Nine-pixel sum |
| out_mom_x | output | 18 | Signed horizontal first moment |
| out_mom_y | output | 18 | Signed vertical first moment |
| out_eof | output | 1 | Last window of the frame evaluated |

## Verification
The bound properties watch, on every cycle, that a record never names a border position, that its total exceeds both the cluster and seed thresholds, that each moment is bounded in magnitude by the total, that a record was preceded two edges earlier by an accepted pixel, and that the frame-end pulse lasts one cycle. The strict-versus-equal boundaries of the seed, total and shape tests, the tie rule of the local-maximum test, the exact moment values, the latency counted against pixel capture under input gaps, and a mid-frame restart can only be shown by the bench's scenarios. The bench compares every record against its own scan of the frame.

// File: rtl/cf_pkg.sv
package cf_pkg;
    localparam int PIX_W    = 14;
    localparam int CRD_W    = 9;
    localparam int SUM_W    = PIX_W + 4;
    localparam int MOM_W    = SUM_W;
    localparam int SHP_W    = 8;
    localparam int SHP_FRAC = 4;
    localparam int PROD_W   = SUM_W + SHP_W;
    localparam int LINES    = 2;

    typedef logic [PIX_W-1:0]        pix_t;
    typedef logic [CRD_W-1:0]        crd_t;
    typedef logic [SUM_W-1:0]        sum_t;
    typedef logic signed [MOM_W-1:0] mom_t;
    typedef logic [SHP_W-1:0]        shp_t;
    typedef logic [PROD_W-1:0]       prod_t;
    typedef logic [2:0][2:0][PIX_W-1:0] win_t;

    typedef struct packed {
        logic vld;
        logic eof;
        crd_t cx;
        crd_t cy;
    } wmeta_t;

    typedef struct packed {
        logic vld;
        logic eof;
        crd_t cx;
        crd_t cy;
        sum_t sum;
        mom_t mx;
        mom_t my;
    } crec_t;
endpackage

// File: rtl/cf_raster.sv
module cf_raster
    import cf_pkg::*;
#(
    parameter int IMG_W = 512,
    parameter int IMG_H = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_vld,
    input  logic pix_sof,
    output crd_t pos_x,
    output crd_t pos_y,
    output logic at_last
);
    localparam crd_t LAST_X = crd_t'(IMG_W - 1);
    localparam crd_t LAST_Y = crd_t'(IMG_H - 1);

    typedef struct packed {
        crd_t x;
        crd_t y;
    } scan_t;

    scan_t st_d, st_q;

    always_comb begin
        pos_x   = pix_sof ? '0 : st_q.x;
        pos_y   = pix_sof ? '0 : st_q.y;
        at_last = (pos_x == LAST_X) && (pos_y == LAST_Y);
        st_d    = st_q;
        if (pix_vld) begin
            if (pos_x == LAST_X) begin
                st_d.x = '0;
                st_d.y = (pos_y == LAST_Y) ? '0 : pos_y + 1'b1;
            end else begin
                st_d.x = pos_x + 1'b1;
                st_d.y = pos_y;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cf_line_store.sv
module cf_line_store
    import cf_pkg::*;
#(
    parameter int IMG_W = 512
) (
    input  logic clk,
    input  logic wr_en,
    input  crd_t pos_x,
    input  pix_t pix_in,
    output pix_t row_up1,
    output pix_t row_up2
);
    localparam int ADDR_W = $clog2(IMG_W);

    logic [ADDR_W-1:0] addr;
    pix_t taps [LINES];
    pix_t feed [LINES];

    assign addr = pos_x[ADDR_W-1:0];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        pix_t mem [IMG_W];
        if (g == 0) begin : g_head
            assign feed[g] = pix_in;
        end else begin : g_tail
            assign feed[g] = taps[g-1];
        end
        always_ff @(posedge clk) begin
            if (wr_en) mem[addr] <= feed[g];
        end
        assign taps[g] = mem[addr];
    end

    assign row_up1 = taps[0];
    assign row_up2 = taps[1];
endmodule

// File: rtl/cf_window.sv
module cf_window
    import cf_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pix_vld,
    input  pix_t   col_top,
    input  pix_t   col_mid,
    input  pix_t   col_bot,
    input  crd_t   pos_x,
    input  crd_t   pos_y,
    input  logic   at_last,
    output win_t   win,
    output wmeta_t meta
);
    typedef struct packed {
        win_t   w;
        wmeta_t m;
    } wst_t;

    wst_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.m.vld = 1'b0;
        st_d.m.eof = 1'b0;
        if (pix_vld) begin
            for (int r = 0; r < 3; r++) begin
                for (int c = 0; c < 2; c++) begin
                    st_d.w[r][c] = st_q.w[r][c+1];
                end
            end
            st_d.w[0][2] = col_top;
            st_d.w[1][2] = col_mid;
            st_d.w[2][2] = col_bot;
            st_d.m.vld   = (pos_x >= crd_t'(2)) && (pos_y >= crd_t'(2));
            st_d.m.cx    = pos_x - 1'b1;
            st_d.m.cy    = pos_y - 1'b1;
            st_d.m.eof   = at_last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win  = st_q.w;
    assign meta = st_q.m;
endmodule

// File: rtl/cf_judge.sv
module cf_judge
    import cf_pkg::*;
(
    input  win_t win,
    input  pix_t seed_thr,
    input  sum_t total_thr,
    input  shp_t shape,
    output logic accept,
    output sum_t sum,
    output mom_t mx,
    output mom_t my
);
    pix_t  centre;
    sum_t  ring, lsum, rsum, tsum, bsum;
    prod_t lhs, rhs;
    logic  peak, seed_ok, total_ok, shape_ok;

    always_comb begin
        centre = win[1][1];
        ring   = '0;
        lsum   = '0;
        rsum   = '0;
        tsum   = '0;
        bsum   = '0;
        peak   = 1'b1;
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                if (!(r == 1 && c == 1)) begin
                    ring = ring + sum_t'(win[r][c]);
                    if (win[r][c] > centre) peak = 1'b0;
                end
                if (c == 0) lsum = lsum + sum_t'(win[r][c]);
                if (c == 2) rsum = rsum + sum_t'(win[r][c]);
                if (r == 0) tsum = tsum + sum_t'(win[r][c]);
                if (r == 2) bsum = bsum + sum_t'(win[r][c]);
            end
        end
        sum      = ring + sum_t'(centre);
        mx       = mom_t'(rsum) - mom_t'(lsum);
        my       = mom_t'(bsum) - mom_t'(tsum);
        lhs      = prod_t'(centre) << SHP_FRAC;
        rhs      = prod_t'(shape) * prod_t'(ring);
        seed_ok  = centre > seed_thr;
        total_ok = sum > total_thr;
        shape_ok = lhs > rhs;
        accept   = seed_ok && total_ok && shape_ok && peak;
    end
endmodule

// File: rtl/cf_cluster_finder.sv
module cf_cluster_finder
    import cf_pkg::*;
#(
    parameter int IMG_W = 512,
    parameter int IMG_H = 512
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic [PIX_W-1:0]  in_pix,
    input  logic [PIX_W-1:0]  cfg_seed,
    input  logic [SUM_W-1:0]  cfg_total,
    input  logic [SHP_W-1:0]  cfg_shape,
    output logic              out_valid,
    output logic [CRD_W-1:0]  out_x,
    output logic [CRD_W-1:0]  out_y,
    output logic [SUM_W-1:0]  out_sum,
    output logic [MOM_W-1:0]  out_mom_x,
    output logic [MOM_W-1:0]  out_mom_y,
    output logic              out_eof
);
    crd_t   pos_x, pos_y;
    logic   at_last;
    pix_t   up1, up2;
    win_t   win;
    wmeta_t meta;
    logic   accept;
    sum_t   w_sum;
    mom_t   w_mx, w_my;
    crec_t  rec_d, rec_q;

    cf_raster #(.IMG_W(IMG_W), .IMG_H(IMG_H)) i_raster (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_vld (in_valid),
        .pix_sof (in_sof),
        .pos_x   (pos_x),
        .pos_y   (pos_y),
        .at_last (at_last)
    );

    cf_line_store #(.IMG_W(IMG_W)) i_lines (
        .clk     (clk),
        .wr_en   (in_valid),
        .pos_x   (pos_x),
        .pix_in  (in_pix),
        .row_up1 (up1),
        .row_up2 (up2)
    );

    cf_window i_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .pix_vld (in_valid),
        .col_top (up2),
        .col_mid (up1),
        .col_bot (in_pix),
        .pos_x   (pos_x),
        .pos_y   (pos_y),
        .at_last (at_last),
        .win     (win),
        .meta    (meta)
    );

    cf_judge i_judge (
        .win       (win),
        .seed_thr  (cfg_seed),
        .total_thr (cfg_total),
        .shape     (cfg_shape),
        .accept    (accept),
        .sum       (w_sum),
        .mx        (w_mx),
        .my        (w_my)
    );

    always_comb begin
        rec_d     = rec_q;
        rec_d.vld = meta.vld && accept;
        rec_d.eof = meta.eof;
        if (meta.vld && accept) begin
            rec_d.cx  = meta.cx;
            rec_d.cy  = meta.cy;
            rec_d.sum = w_sum;
            rec_d.mx  = w_mx;
            rec_d.my  = w_my;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    assign out_valid = rec_q.vld;
    assign out_eof   = rec_q.eof;
    assign out_x     = rec_q.cx;
    assign out_y     = rec_q.cy;
    assign out_sum   = rec_q.sum;
    assign out_mom_x = rec_q.mx;
    assign out_mom_y = rec_q.my;
endmodule

// File: rtl/cf_cluster_finder_chk.sv
module cf_cluster_finder_chk
    import cf_pkg::*;
#(
    parameter int IMG_W = 512,
    parameter int IMG_H = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [PIX_W-1:0] cfg_seed,
    input logic [SUM_W-1:0] cfg_total,
    input logic             out_valid,
    input logic [CRD_W-1:0] out_x,
    input logic [CRD_W-1:0] out_y,
    input logic [SUM_W-1:0] out_sum,
    input logic [MOM_W-1:0] out_mom_x,
    input logic [MOM_W-1:0] out_mom_y,
    input logic             out_eof
);
    localparam crd_t MAX_CX = crd_t'(IMG_W - 2);
    localparam crd_t MAX_CY = crd_t'(IMG_H - 2);

    logic signed [MOM_W:0] sum_s, mx_s, my_s;
    assign sum_s = $signed({1'b0, out_sum});
    assign mx_s  = (MOM_W+1)'($signed(out_mom_x));
    assign my_s  = (MOM_W+1)'($signed(out_mom_y));

    p_seed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sum > SUM_W'($past(cfg_seed))));

    p_total_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sum > $past(cfg_total)));

    p_border_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_x >= crd_t'(1) && out_x <= MAX_CX &&
                       out_y >= crd_t'(1) && out_y <= MAX_CY));

    p_moment_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (mx_s <= sum_s && -mx_s <= sum_s &&
                       my_s <= sum_s && -my_s <= sum_s));

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2));

    p_eof_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |=> !out_eof);

    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_eof));
endmodule

bind cf_cluster_finder cf_cluster_finder_chk #(.IMG_W(IMG_W), .IMG_H(IMG_H)) i_chk (.*);

// File: tb/test_cf_cluster_finder.sv
`timescale 1ns/1ps
module test_cf_cluster_finder;
    localparam int W = 16;
    localparam int H = 12;
    localparam int MAXREC = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic [13:0] in_pix = '0;
    logic [13:0] cfg_seed = 14'd50;
    logic [17:0] cfg_total = 18'd100;
    logic [7:0]  cfg_shape = 8'd16;
    logic        out_valid, out_eof;
    logic [8:0]  out_x, out_y;
    logic [17:0] out_sum, out_mom_x, out_mom_y;

    cf_cluster_finder #(.IMG_W(W), .IMG_H(H)) i_cf_cluster_finder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_pix(in_pix), .cfg_seed(cfg_seed), .cfg_total(cfg_total),
        .cfg_shape(cfg_shape), .out_valid(out_valid), .out_x(out_x),
        .out_y(out_y), .out_sum(out_sum), .out_mom_x(out_mom_x),
        .out_mom_y(out_mom_y), .out_eof(out_eof)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int img [H][W];
    int drv [H][W];
    int n_chk = 0;
    int n_fail = 0;

    int rx [MAXREC], ry [MAXREC], rs [MAXREC], rmx [MAXREC], rmy [MAXREC], rc [MAXREC];
    int nrec = 0;
    int eof_n = 0;
    int eof_c = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (nrec < MAXREC) begin
                    rx[nrec]  = int'(out_x);
                    ry[nrec]  = int'(out_y);
                    rs[nrec]  = int'(out_sum);
                    rmx[nrec] = int'($signed(out_mom_x));
                    rmy[nrec] = int'($signed(out_mom_y));
                    rc[nrec]  = cyc;
                end
                nrec = nrec + 1;
            end
            if (out_eof) begin
                eof_n = eof_n + 1;
                eof_c = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic fill_noise();
        for (int y = 0; y < H; y++)
            for (int x = 0; x < W; x++)
                img[y][x] = (x * 7 + y * 13) % 4;
    endtask

    task automatic put_cluster(input int cx, input int cy, input int c, input int n);
        for (int dy = -1; dy <= 1; dy++)
            for (int dx = -1; dx <= 1; dx++)
                img[cy+dy][cx+dx] = n;
        img[cy][cx] = c;
    endtask

    task automatic check_frame(input string tag, input int base, input int ebase);
        int e = 0;
        for (int cy = 1; cy < H - 1; cy++) begin
            for (int cx = 1; cx < W - 1; cx++) begin
                int c = img[cy][cx];
                int ring = 0, l = 0, r = 0, t = 0, b = 0;
                bit pk = 1;
                for (int dy = -1; dy <= 1; dy++) begin
                    for (int dx = -1; dx <= 1; dx++) begin
                        int v = img[cy+dy][cx+dx];
                        if (!(dx == 0 && dy == 0)) begin
                            ring += v;
                            if (v > c) pk = 0;
                        end
                        if (dx == -1) l += v;
                        if (dx == 1)  r += v;
                        if (dy == -1) t += v;
                        if (dy == 1)  b += v;
                    end
                end
                if (c > int'(cfg_seed) && (c + ring) > int'(cfg_total) &&
                    c * 16 > int'(cfg_shape) * ring && pk) begin
                    int i = base + e;
                    if (i < nrec && i < MAXREC) begin
                        chk(rx[i] == cx, "R6", {tag, " x"}, rx[i], cx);
                        chk(ry[i] == cy, "R6", {tag, " y"}, ry[i], cy);
                        chk(rs[i] == c + ring, "R6", {tag, " sum"}, rs[i], c + ring);
                        chk(rmx[i] == r - l, "R6", {tag, " mom_x"}, rmx[i], r - l);
                        chk(rmy[i] == b - t, "R6", {tag, " mom_y"}, rmy[i], b - t);
                        chk(rc[i] == drv[cy+1][cx+1] + 2, "R7", {tag, " latency"},
                            rc[i], drv[cy+1][cx+1] + 2);
                    end
                    e++;
                end
            end
        end
        chk(nrec - base == e, tag, "record count", nrec - base, e);
        chk(eof_n - ebase == 1, "R8", {tag, " eof count"}, eof_n - ebase, 1);
        chk(eof_c == drv[H-1][W-1] + 2, "R8", {tag, " eof cycle"}, eof_c, drv[H-1][W-1] + 2);
    endtask

    task automatic run_frame(input string tag, input bit gaps, input int prefix);
        int base = nrec;
        int ebase = eof_n;
        for (int i = 0; i < prefix; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_pix   = '0;
        end
        for (int y = 0; y < H; y++) begin
            for (int x = 0; x < W; x++) begin
                if (gaps) begin
                    repeat ((x + y) % 3) begin
                        @(negedge clk);
                        in_valid = 1'b0;
                        in_sof   = 1'b0;
                        in_pix   = 14'h3fff;
                    end
                end
                @(negedge clk);
                in_valid  = 1'b1;
                in_sof    = (x == 0 && y == 0);
                in_pix    = 14'(img[y][x]);
                drv[y][x] = cyc;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        repeat (5) @(negedge clk);
        check_frame(tag, base, ebase);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid in reset", int'(out_valid), 0);
        chk(out_eof == 1'b0, "R10", "out_eof in reset", int'(out_eof), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid after reset", int'(out_valid), 0);
    endtask

    task automatic t_single();
        cfg_seed = 14'd50; cfg_total = 18'd100; cfg_shape = 8'd16;
        fill_noise();
        img[3][4] = 10; img[3][5] = 20; img[3][6] = 30;
        img[4][4] = 15; img[4][5] = 200; img[4][6] = 25;
        img[5][4] = 5;  img[5][5] = 40; img[5][6] = 12;
        run_frame("R6 single", 1'b0, 0);
    endtask

    task automatic t_seed_edge();
        cfg_seed = 14'd50; cfg_total = 18'd60; cfg_shape = 8'd16;
        fill_noise();
        put_cluster(3, 3, 50, 5);
        put_cluster(10, 7, 51, 5);
        run_frame("R1 seed edge", 1'b0, 0);
    endtask

    task automatic t_total_edge();
        cfg_seed = 14'd50; cfg_total = 18'd200; cfg_shape = 8'd16;
        fill_noise();
        put_cluster(4, 3, 120, 10);
        put_cluster(11, 8, 121, 10);
        run_frame("R2 total edge", 1'b0, 0);
    endtask

    task automatic t_shape_edge();
        cfg_seed = 14'd50; cfg_total = 18'd100; cfg_shape = 8'd24;
        fill_noise();
        put_cluster(4, 4, 150, 12);
        img[3][3] = 16;
        put_cluster(11, 7, 151, 12);
        img[6][10] = 16;
        run_frame("R3 shape edge", 1'b0, 0);
    endtask

    task automatic t_peak();
        cfg_seed = 14'd50; cfg_total = 18'd100; cfg_shape = 8'd4;
        fill_noise();
        put_cluster(4, 4, 100, 5);
        img[4][5] = 101;
        put_cluster(10, 7, 100, 5);
        img[7][11] = 100;
        run_frame("R4 local peak", 1'b0, 0);
    endtask

    task automatic t_border();
        cfg_seed = 14'd50; cfg_total = 18'd100; cfg_shape = 8'd16;
        fill_noise();
        img[5][0] = 300; img[3][W-1] = 300; img[0][7] = 300;
        img[H-1][6] = 300; img[0][0] = 300; img[H-1][W-1] = 300;
        put_cluster(7, 6, 200, 10);
        run_frame("R5 border", 1'b0, 0);
    endtask

    task automatic t_gaps();
        cfg_seed = 14'd50; cfg_total = 18'd100; cfg_shape = 8'd16;
        fill_noise();
        put_cluster(12, 9, 300, 20);
        put_cluster(2, 1, 90, 3);
        run_frame("R7 gaps", 1'b1, 0);
    endtask

    task automatic t_restart();
        cfg_seed = 14'd50; cfg_total = 18'd100; cfg_shape = 8'd16;
        fill_noise();
        put_cluster(8, 6, 250, 10);
        run_frame("R9 restart", 1'b0, 3 * W + 5);
    endtask

    initial begin
        t_reset();
        t_single();
        t_seed_edge();
        t_total_edge();
        t_shape_edge();
        t_peak();
        t_border();
        t_gaps();
        t_restart();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule